// File: doc/BRIEF.md
# Threshold Hit Finder

The block watches a bank of parallel channels. Each channel carries a signed sample stream that has already been filtered and pedestal-subtracted. On every accepted tick it takes one sample per channel together with a tick number. Each channel keeps its own open or closed hit state. A hit opens on the first sample strictly greater than a shared threshold. While the hit is open, the channel counts the ticks spent above the threshold and sums the sample values. When the signal comes back to the threshold or below, the channel produces one compact record: channel index, start tick, time over threshold and integrated charge.

Completed hits whose time over threshold is below a programmable minimum length are dropped. A flush request closes every open hit as though its signal had dropped on that tick. Records that complete on the same tick are staged and pushed one per cycle, lowest channel first, into a record queue that drives a valid/ready output stream.

Both streams use valid/ready handshakes. The input side, which carries ticks and flushes, stalls while records are still waiting to enter the queue. The output side holds each record steady until the consumer accepts it. A sticky flag records that the queue has ever been completely full.

Top module: `hit_finder`

## Requirements
- R1: On an accepted tick with `flush` low, a closed channel whose sample is strictly greater than `thresh` (signed compare) opens a hit whose start tick is that tick's `in_tick`.
- R2: A sample exactly equal to `thresh` counts as below: it neither opens a hit nor extends an open one.
- R3: On the first accepted tick whose sample is at or below `thresh`, an open hit closes. Its record carries time over threshold equal to the number of ticks above threshold and charge equal to the signed sum of those samples.
- R4: A closed hit whose time over threshold is below `min_len` produces no record. A `min_len` of 0 or 1 keeps every hit.
- R5: Time over threshold saturates at 65535 and charge saturates at the signed 32-bit limits (0x7FFFFFFF or 0x80000000).
- R6: Records from hits that close on the same tick leave the output in ascending channel order.
- R7: When a flush is accepted, every open hit closes with its totals as they stood before that tick. The tick's samples are neither accumulated nor able to open a hit.
- R8: `out_valid` with `out_ready` low holds the record unchanged on the next cycle. `in_ready` is low while any closed record has not yet entered the queue.
- R9: `overflow` goes high once the record queue (16 entries by default) is full and stays high until reset.
- R10: After reset `out_valid` is 0, `in_ready` is 1, `overflow` is 0 and every channel is closed.
- R11: Channels are independent: activity on one channel never opens, extends or closes a hit on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A tick of samples is offered |
| in_ready | output | 1 | Block can accept a tick or a flush |
| in_tick | input | 32 | Tick number of the offered samples |
| in_samples | input | NCH*SAMP_W (256) | Signed samples, channel i at bits [i*SAMP_W +: SAMP_W] |
| flush | input | 1 | Close all open hits; accepted when in_ready is high |
| thresh | input | SAMP_W (16) | Signed hit threshold |
| min_len | input | 16 | Minimum time over threshold for a record |
| out_valid | output | 1 | A hit record is available |
| out_ready | input | 1 | Consumer accepts the record |
| out_chan | output | 4 | Channel index of the record |
| out_start | output | 32 | Tick on which the hit opened |
| out_tot | output | 16 | Time over threshold in ticks, saturating |
| out_charge | output | 32 | Signed integrated charge, saturating |
| overflow | output | 1 | Sticky: record queue has been full |

## Verification
The assertions assume that `in_valid`, `flush` and the sample bus are sampled only on cycles where `in_ready` is high, and that `thresh` and `min_len` stay constant while hits are open. The stimulus changes the threshold and minimum length only after every channel has returned below threshold and all records have drained. It offers ticks and flushes only when `in_ready` is seen high, and it toggles `out_ready` only between cycles. Channels that are not under test are held well below the threshold so that they do not produce extra records.

// File: rtl/hf_pkg.sv
package hf_pkg;
  localparam int unsigned CHAN_W = 4;
  localparam int unsigned TICK_W = 32;
  localparam int unsigned TOT_W  = 16;
  localparam int unsigned Q_W    = 32;

  typedef struct packed {
    logic [CHAN_W-1:0]      chan;
    logic [TICK_W-1:0]      start;
    logic [TOT_W-1:0]       tot;
    logic signed [Q_W-1:0]  charge;
  } hit_rec_t;
endpackage

// File: rtl/hf_channel.sv
module hf_channel
  import hf_pkg::*;
#(
  parameter int unsigned SAMP_W = 16,
  parameter int unsigned IDX    = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_go,
  input  logic                     flush_go,
  input  logic signed [SAMP_W-1:0] sample,
  input  logic [TICK_W-1:0]        tick,
  input  logic signed [SAMP_W-1:0] thresh,
  input  logic [TOT_W-1:0]         min_len,
  output logic                     open_o,
  output logic                     close_o,
  output hit_rec_t                 rec_o
);
  localparam logic signed [Q_W-1:0] Q_MAX = {1'b0, {(Q_W-1){1'b1}}};
  localparam logic signed [Q_W-1:0] Q_MIN = {1'b1, {(Q_W-1){1'b0}}};

  logic                    open_q;
  logic [TICK_W-1:0]       start_q;
  logic [TOT_W-1:0]        tot_q;
  logic signed [Q_W-1:0]   q_q;

  logic                    above;
  logic [TOT_W-1:0]        tot_inc;
  logic signed [Q_W:0]     q_wide;
  logic signed [Q_W-1:0]   q_inc;
  logic signed [Q_W-1:0]   samp_ext;
  logic                    ends;

  always_comb begin
    above    = sample > thresh;
    tot_inc  = (tot_q == {TOT_W{1'b1}}) ? tot_q : tot_q + 1'b1;
    samp_ext = {{(Q_W-SAMP_W){sample[SAMP_W-1]}}, sample};
    q_wide   = {q_q[Q_W-1], q_q} + {samp_ext[Q_W-1], samp_ext};
    if (q_wide[Q_W] != q_wide[Q_W-1])
      q_inc = q_wide[Q_W] ? Q_MIN : Q_MAX;
    else
      q_inc = q_wide[Q_W-1:0];
    ends     = open_q && (flush_go || (tick_go && !above));
  end

  assign close_o = ends && (tot_q >= min_len);
  assign open_o  = open_q;
  assign rec_o   = '{chan: CHAN_W'(IDX), start: start_q, tot: tot_q, charge: q_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      start_q <= '0;
      tot_q   <= '0;
      q_q     <= '0;
    end else if (flush_go) begin
      open_q  <= 1'b0;
    end else if (tick_go) begin
      if (!open_q) begin
        if (above) begin
          open_q  <= 1'b1;
          start_q <= tick;
          tot_q   <= {{(TOT_W-1){1'b0}}, 1'b1};
          q_q     <= samp_ext;
        end
      end else if (above) begin
        tot_q <= tot_inc;
        q_q   <= q_inc;
      end else begin
        open_q <= 1'b0;
      end
    end
  end

  // R1: a freshly opened hit carries the tick on which it was seen
  a_r1_start_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> (start_q == $past(tick)));

  // R3: an open hit always has at least one tick counted
  a_r3_tot_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (tot_q != '0));

  // R2: an open hit fed a sample at threshold is closed next cycle
  a_r2_equal_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && open_q && (sample == thresh)) |=> !open_q);
endmodule

// File: rtl/hf_gather.sv
module hf_gather
  import hf_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        close_i,
  input  hit_rec_t [NCH-1:0]    rec_i,
  input  logic                  fifo_full,
  output logic                  push_o,
  output hit_rec_t              push_rec_o,
  output logic                  busy_o
);
  localparam int unsigned SELW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]     pend_q;
  hit_rec_t [NCH-1:0] recs_q;
  logic [SELW-1:0]    sel;
  logic               found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (pend_q[i] && !found) begin
        sel   = SELW'(i);
        found = 1'b1;
      end
    end
  end

  assign push_o     = found && !fifo_full;
  assign push_rec_o = recs_q[sel];
  assign busy_o     = |pend_q;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        recs_q[g] <= '0;
      end else if (close_i[g]) begin
        pend_q[g] <= 1'b1;
        recs_q[g] <= rec_i[g];
      end else if (push_o && (sel == SELW'(g))) begin
        pend_q[g] <= 1'b0;
      end
    end
  end

  // R6: each push retires exactly one staged record
  a_r6_one_per_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

  // R8: new closures only arrive when nothing is staged
  a_r8_stage_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (|close_i) |-> !busy_o);
endmodule

// File: rtl/hf_fifo.sv
module hf_fifo
  import hf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  hit_rec_t push_data,
  input  logic     pop,
  output logic     full,
  output logic     empty,
  output hit_rec_t head,
  output logic     overflow
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  hit_rec_t       mem [DEPTH];
  logic [AW:0]    wp_q, rp_q;
  logic           ovf_q;

  assign empty    = (wp_q == rp_q);
  assign full     = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign head     = mem[rp_q[AW-1:0]];
  assign overflow = ovf_q;

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp_q[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push && !full) wp_q <= wp_q + 1'b1;
      if (pop && !empty) rp_q <= rp_q + 1'b1;
      if (full) ovf_q <= 1'b1;
    end
  end

  // R9: the stager never offers a record to a full queue
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9: overflow is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_q) |-> ovf_q);
endmodule

// File: rtl/hit_finder.sv
module hit_finder
  import hf_pkg::*;
#(
  parameter int unsigned NCH        = 16,
  parameter int unsigned SAMP_W     = 16,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [TICK_W-1:0]     in_tick,
  input  logic [NCH*SAMP_W-1:0] in_samples,
  input  logic                  flush,
  input  logic [SAMP_W-1:0]     thresh,
  input  logic [TOT_W-1:0]      min_len,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [CHAN_W-1:0]     out_chan,
  output logic [TICK_W-1:0]     out_start,
  output logic [TOT_W-1:0]      out_tot,
  output logic [Q_W-1:0]        out_charge,
  output logic                  overflow
);
  logic               busy;
  logic               tick_go, flush_go;
  logic [NCH-1:0]     close_v, open_v;
  hit_rec_t [NCH-1:0] rec_v;
  logic               push, fifo_full, fifo_empty;
  hit_rec_t           push_rec, head;

  assign in_ready = !busy;
  assign flush_go = flush && in_ready;
  assign tick_go  = in_valid && in_ready && !flush;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hf_channel #(.SAMP_W(SAMP_W), .IDX(g)) i_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_go  (tick_go),
      .flush_go (flush_go),
      .sample   ($signed(in_samples[g*SAMP_W +: SAMP_W])),
      .tick     (in_tick),
      .thresh   ($signed(thresh)),
      .min_len  (min_len),
      .open_o   (open_v[g]),
      .close_o  (close_v[g]),
      .rec_o    (rec_v[g])
    );
  end

  hf_gather #(.NCH(NCH)) i_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .close_i    (close_v),
    .rec_i      (rec_v),
    .fifo_full  (fifo_full),
    .push_o     (push),
    .push_rec_o (push_rec),
    .busy_o     (busy)
  );

  hf_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_rec),
    .pop       (out_valid && out_ready),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .head      (head),
    .overflow  (overflow)
  );

  assign out_valid  = !fifo_empty;
  assign out_chan   = head.chan;
  assign out_start  = head.start;
  assign out_tot    = head.tot;
  assign out_charge = head.charge;

  // R8: a stalled record stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) &&
      $stable(out_start) && $stable(out_tot) && $stable(out_charge)));

  // R7: after an accepted flush no channel is open
  a_r7_flush_closes: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go |=> (open_v == '0));

  // R10: the output stream is idle straight after reset
  a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/test_hit_finder.sv
`timescale 1ns/1ps
module test_hit_finder;
  localparam int NCH = 16;
  localparam int SW  = 16;
  localparam int NV  = 15;
  localparam logic [31:0] TBASE = 32'd1000;

  // entry: sample(16) | closes(1) | tot(16) | charge(32) | start index(8)
  localparam logic [72:0] VEC [NV] = '{
    {16'd50,    1'b0, 16'd0, 32'd0,     8'd0},
    {16'd101,   1'b0, 16'd0, 32'd0,     8'd0},
    {16'd200,   1'b0, 16'd0, 32'd0,     8'd0},
    {16'd100,   1'b1, 16'd2, 32'd301,   8'd1},
    {16'd100,   1'b0, 16'd0, 32'd0,     8'd0},
    {16'd150,   1'b0, 16'd0, 32'd0,     8'd0},
    {16'd300,   1'b0, 16'd0, 32'd0,     8'd0},
    {16'd99,    1'b1, 16'd2, 32'd450,   8'd5},
    {16'hFFFB,  1'b0, 16'd0, 32'd0,     8'd0},
    {16'd101,   1'b0, 16'd0, 32'd0,     8'd0},
    {16'd101,   1'b0, 16'd0, 32'd0,     8'd0},
    {16'd101,   1'b0, 16'd0, 32'd0,     8'd0},
    {16'd0,     1'b1, 16'd3, 32'd303,   8'd9},
    {16'd32767, 1'b0, 16'd0, 32'd0,     8'd0},
    {16'h8000,  1'b1, 16'd1, 32'd32767, 8'd13}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, flush = 0, out_ready = 0;
  logic [31:0] in_tick = 0;
  logic [NCH*SW-1:0] in_samples = '0;
  logic [SW-1:0] thresh = 16'd100;
  logic [15:0] min_len = 16'd1;
  logic in_ready, out_valid, overflow;
  logic [3:0] out_chan;
  logic [31:0] out_start, out_charge;
  logic [15:0] out_tot;

  int nchk = 0, nfail = 0, rc = 0;
  logic [3:0]  r_ch [64];
  logic [31:0] r_st [64];
  logic [15:0] r_tot [64];
  logic [31:0] r_q [64];
  logic [31:0] tk = 32'd5000;

  always #2.5 clk = ~clk;

  hit_finder i_hit_finder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tick(in_tick), .in_samples(in_samples), .flush(flush),
    .thresh(thresh), .min_len(min_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_chan(out_chan), .out_start(out_start),
    .out_tot(out_tot), .out_charge(out_charge), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rc < 64) begin
      r_ch[rc] <= out_chan; r_st[rc] <= out_start;
      r_tot[rc] <= out_tot; r_q[rc] <= out_charge;
      rc <= rc + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_rec(input int idx, input logic [3:0] ch, input logic [31:0] st,
                           input logic [15:0] tot, input logic [31:0] q, input string tag);
    check(r_ch[idx] == ch,   {tag, " chan"},   64'(r_ch[idx]), 64'(ch));
    check(r_st[idx] == st,   {tag, " start"},  64'(r_st[idx]), 64'(st));
    check(r_tot[idx] == tot, {tag, " tot"},    64'(r_tot[idx]), 64'(tot));
    check(r_q[idx] == q,     {tag, " charge"}, 64'(r_q[idx]), 64'(q));
  endtask

  function automatic logic [NCH*SW-1:0] fill(input logic [SW-1:0] v);
    logic [NCH*SW-1:0] r;
    for (int i = 0; i < NCH; i++) r[i*SW +: SW] = v;
    return r;
  endfunction

  function automatic logic [NCH*SW-1:0] put(input logic [NCH*SW-1:0] b, input int ch, input logic [SW-1:0] v);
    logic [NCH*SW-1:0] r;
    r = b;
    r[ch*SW +: SW] = v;
    return r;
  endfunction

  task automatic tick_in(input logic [NCH*SW-1:0] s, input logic [31:0] t, input logic v, input logic fl);
    while (!in_ready) @(negedge clk);
    in_valid = v; flush = fl; in_samples = s; in_tick = t;
    @(negedge clk);
    in_valid = 0; flush = 0;
  endtask

  task automatic one(input int ch, input logic [SW-1:0] v);
    tick_in(put(fill(16'd0), ch, v), tk, 1'b1, 1'b0);
    tk++;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1 out_ready = v;
    @(negedge clk);
  endtask

  initial begin
    #(190000 * 5);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int base;
    logic [31:0] st;
    repeat (4) @(negedge clk);
    rst_n = 1;
    settle(2);
    // R10 reset state
    check(out_valid == 0, "R10 out_valid", 64'(out_valid), 0);
    check(in_ready == 1,  "R10 in_ready",  64'(in_ready), 1);
    check(overflow == 0,  "R10 overflow",  64'(overflow), 0);
    set_ready(1);

    // table walk on channel 3 (R1 R2 R3)
    for (int i = 0; i < NV; i++) begin
      int exp_rc;
      tick_in(put(fill(16'd0), 3, VEC[i][72:57]), TBASE + 32'(i), 1'b1, 1'b0);
      settle(4);
      exp_rc = base + 0;
      if (VEC[i][56]) begin
        base++;
        check(rc == base, "R3 record count", 64'(rc), 64'(base));
        check_rec(base - 1, 4'd3, TBASE + 32'(VEC[i][7:0]), VEC[i][55:40], VEC[i][39:8], "R1/R3 table");
      end else begin
        check(rc == exp_rc, "R2 no record", 64'(rc), 64'(exp_rc));
      end
    end

    // R4 minimum length
    min_len = 16'd3;
    base = rc;
    one(2, 16'd200); one(2, 16'd200); one(2, 16'd0);
    settle(4);
    check(rc == base, "R4 short hit dropped", 64'(rc), 64'(base));
    st = tk;
    one(2, 16'd200); one(2, 16'd200); one(2, 16'd200); one(2, 16'd0);
    settle(4);
    check(rc == base + 1, "R4 long hit kept", 64'(rc), 64'(base + 1));
    check_rec(rc - 1, 4'd2, st, 16'd3, 32'd600, "R4");
    min_len = 16'd0;
    st = tk;
    one(2, 16'd150); one(2, 16'd0);
    settle(4);
    check(rc == base + 2, "R4 min_len zero", 64'(rc), 64'(base + 2));
    check_rec(rc - 1, 4'd2, st, 16'd1, 32'd150, "R4 zero");
    min_len = 16'd1;

    // R6 ordering and R8 input stall
    base = rc;
    st = tk;
    tick_in(put(put(put(put(fill(16'd0), 15, 16'd500), 0, 16'd400), 7, 16'd300), 2, 16'd200), tk, 1'b1, 1'b0);
    tk++;
    tick_in(fill(16'd0), tk, 1'b1, 1'b0);
    tk++;
    check(in_ready == 0, "R8 in_ready low while staged", 64'(in_ready), 0);
    settle(10);
    check(rc == base + 4, "R6 record count", 64'(rc), 64'(base + 4));
    check_rec(base,     4'd0,  st, 16'd1, 32'd400, "R6 first");
    check_rec(base + 1, 4'd2,  st, 16'd1, 32'd200, "R6 second");
    check_rec(base + 2, 4'd7,  st, 16'd1, 32'd300, "R6 third");
    check_rec(base + 3, 4'd15, st, 16'd1, 32'd500, "R6 fourth");

    // R7 flush
    base = rc;
    st = tk;
    one(5, 16'd200); one(5, 16'd200);
    tick_in(put(put(fill(16'd0), 5, 16'd300), 6, 16'd300), tk, 1'b1, 1'b1);
    tk++;
    settle(4);
    check(rc == base + 1, "R7 flush record", 64'(rc), 64'(base + 1));
    check_rec(base, 4'd5, st, 16'd2, 32'd400, "R7");
    tick_in(fill(16'd0), tk, 1'b1, 1'b0);
    tk++;
    settle(4);
    check(rc == base + 1, "R7 no late record", 64'(rc), 64'(base + 1));

    // R11 negative threshold, other channels held low
    thresh = 16'hFFF6;
    base = rc;
    st = tk;
    tick_in(put(fill(16'hFF9C), 4, 16'hFFFB), tk, 1'b1, 1'b0); tk++;
    tick_in(put(fill(16'hFF9C), 4, 16'hFFF6), tk, 1'b1, 1'b0); tk++;
    settle(4);
    check(rc == base + 1, "R11 one record", 64'(rc), 64'(base + 1));
    check_rec(base, 4'd4, st, 16'd1, 32'hFFFFFFFB, "R11");
    thresh = 16'd100;

    // R9 queue fill and R8 hold
    set_ready(0);
    base = rc;
    st = tk;
    tick_in(fill(16'd500), tk, 1'b1, 1'b0); tk++;
    tick_in(fill(16'd0), tk, 1'b1, 1'b0); tk++;
    settle(24);
    check(overflow == 1, "R9 overflow set", 64'(overflow), 1);
    check(out_valid == 1 && out_chan == 4'd0, "R8 head valid", 64'(out_chan), 0);
    settle(3);
    check(out_chan == 4'd0 && out_start == st, "R8 hold", 64'(out_start), 64'(st));
    set_ready(1);
    settle(24);
    check(rc == base + 16, "R9 drained", 64'(rc), 64'(base + 16));
    check_rec(base + 15, 4'd15, st, 16'd1, 32'd500, "R9 last");
    check(overflow == 1, "R9 sticky", 64'(overflow), 1);

    // R5 saturation on channel 1
    base = rc;
    st = tk;
    for (int k = 0; k < 65600; k++) begin
      tick_in(put(fill(16'd0), 1, 16'd32767), tk, 1'b1, 1'b0);
      tk++;
    end
    one(1, 16'd0);
    settle(4);
    check(rc == base + 1, "R5 record", 64'(rc), 64'(base + 1));
    check_rec(base, 4'd1, st, 16'hFFFF, 32'h7FFFFFFF, "R5 saturate");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule